// File: doc/BRIEF.md
# Parallel handoff signal state tracker

This block follows the handshake between a material-handling transport and a processing tool while a carrier is loaded or unloaded. The two sides talk over ten parallel boolean wires. On every clock the tracker decodes one handshake state from the present wire levels by a fixed priority. It does not step from edge to edge, so the state always reflects the wires and needs no history.

The decoded state is registered. The block also gives a one-cycle strobe whenever the registered state takes a new value, and it holds the state that was current before the most recent change. A separate supervisor that watches handshake timing can drive a force input. While that input is high, the tracker reports a reserved fault code in place of the decoded state. The wires are assumed to be already synchronised and free of glitches.

Top module: `hs_tracker`

## Requirements
- R1: The bit positions of `wires_i` are: bit 0 carrier select 0, bit 1 carrier select 1, bit 2 VALID, bit 3 TR_REQ, bit 4 BUSY, bit 5 COMPT, bit 6 L_REQ, bit 7 U_REQ, bit 8 READY, bit 9 ES. While ES (bit 9) is high, the decoded state is EmergencyStop (code 7), whatever the other bits are. Once ES falls, the state is decoded again from the wires as they stand.
- R2: If ES is low and COMPT (bit 5) is high, the state is Complete (code 6). This holds whatever BUSY, VALID, L_REQ, U_REQ and the carrier selects are.
- R3: If ES and COMPT are low and BUSY (bit 4) is high, the state is Transferring (code 5).
- R4: If ES, COMPT and BUSY are all low, L_REQ (bit 6) gives LoadReady (code 3) and U_REQ (bit 7) gives UnloadReady (code 4). When both are high, L_REQ wins. VALID is not needed for either.
- R5: If none of ES, COMPT, BUSY, L_REQ or U_REQ is high, the state depends on VALID and the carrier selects. VALID together with either carrier select gives ValidAsserted (code 2). A carrier select without VALID gives CarrierPresent (code 1). Anything else gives Idle (code 0), and this includes VALID with no carrier select.
- R6: TR_REQ (bit 3) and READY (bit 8) have no effect on the state or on the strobe.
- R7: `state_o` shows the state decoded from the inputs sampled at the previous rising clock edge. `state_chg_o` is high for exactly the cycles in which `state_o` differs from its value one cycle earlier. Inputs that leave the decoded state unchanged produce no strobe.
- R8: When `state_o` changes, `prev_state_o` takes the value that `state_o` had just before the change. Otherwise `prev_state_o` holds its value.
- R9: While `fault_force_i` is high, the state is Fault (code 8), and this overrides ES. When `fault_force_i` falls, decoding from the wires resumes.
- R10: A synchronous active-high `rst` sets `state_o` and `prev_state_o` to Idle (code 0) and holds `state_chg_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wires_i | input | 10 | Handshake wire levels (bit map in R1) |
| fault_force_i | input | 1 | Supervisor request to report Fault |
| state_o | output | 4 | Registered handshake state code |
| state_chg_o | output | 1 | One-cycle strobe when state_o changes |
| prev_state_o | output | 4 | State held before the latest change |

## Verification
A wrong priority in the decoder puts a wrong code on `state_o` one clock after the offending wire pattern is applied. The bench compares every cycle, so the error is seen at once. A fault in the change logic shows in the same cycle: a strobe when the code is unchanged, a missing strobe when it changed, or a `prev_state_o` that does not match the code shown just before. The directed load trace must produce exactly six strobes, including the brief return to LoadReady after BUSY falls. Miscounted transitions there point at the ordering of the BUSY and L_REQ terms.

// File: rtl/hs_pkg.sv
package hs_pkg;

    localparam int HS_WIRES = 10;
    localparam int STATE_W  = 4;

    // Wire positions inside the input vector
    localparam int B_CS0   = 0;
    localparam int B_CS1   = 1;
    localparam int B_VALID = 2;
    localparam int B_TRREQ = 3;
    localparam int B_BUSY  = 4;
    localparam int B_COMPT = 5;
    localparam int B_LREQ  = 6;
    localparam int B_UREQ  = 7;
    localparam int B_READY = 8;
    localparam int B_ES    = 9;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE     = 4'd0,
        ST_CARRIER  = 4'd1,
        ST_VALID    = 4'd2,
        ST_LOAD_RDY = 4'd3,
        ST_UNLD_RDY = 4'd4,
        ST_XFER     = 4'd5,
        ST_DONE     = 4'd6,
        ST_ESTOP    = 4'd7,
        ST_FAULT    = 4'd8
    } hs_state_e;

    // Wires that take part in decoding, gathered once
    typedef struct packed {
        logic estop;
        logic compt;
        logic busy;
        logic lreq;
        logic ureq;
        logic valid;
        logic carrier;
    } hs_flags_t;

    function automatic hs_flags_t hs_gather(input logic [HS_WIRES-1:0] w);
        hs_flags_t f;
        f.estop   = w[B_ES];
        f.compt   = w[B_COMPT];
        f.busy    = w[B_BUSY];
        f.lreq    = w[B_LREQ];
        f.ureq    = w[B_UREQ];
        f.valid   = w[B_VALID];
        f.carrier = w[B_CS0] | w[B_CS1];
        return f;
    endfunction

    // Priority order: stop, completion, transfer, requests, valid, carrier
    function automatic hs_state_e hs_rank(input hs_flags_t f);
        hs_state_e s;
        if (f.estop)                  s = ST_ESTOP;
        else if (f.compt)             s = ST_DONE;
        else if (f.busy)              s = ST_XFER;
        else if (f.lreq)              s = ST_LOAD_RDY;
        else if (f.ureq)              s = ST_UNLD_RDY;
        else if (f.valid & f.carrier) s = ST_VALID;
        else if (f.carrier)           s = ST_CARRIER;
        else                          s = ST_IDLE;
        return s;
    endfunction

endpackage

// File: rtl/hs_decode.sv
module hs_decode
    import hs_pkg::*;
#(
    parameter int NW = HS_WIRES
) (
    input  logic [NW-1:0] wires,
    output hs_state_e     decoded
);
    hs_flags_t flags;

    always_comb begin
        flags   = hs_gather(wires);
        decoded = hs_rank(flags);
    end
endmodule

// File: rtl/hs_override.sv
module hs_override
    import hs_pkg::*;
(
    input  logic      force_fault,
    input  hs_state_e decoded,
    output hs_state_e chosen
);
    always_comb begin
        chosen = force_fault ? ST_FAULT : decoded;
    end
endmodule

// File: rtl/hs_state_reg.sv
module hs_state_reg
    import hs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  hs_state_e nxt,
    output hs_state_e cur,
    output hs_state_e prev,
    output logic      chg
);
    logic differs;

    always_comb begin
        differs = (nxt != cur);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= ST_IDLE;
            prev <= ST_IDLE;
            chg  <= 1'b0;
        end else begin
            chg <= differs;
            if (differs) begin
                prev <= cur;
                cur  <= nxt;
            end
        end
    end
endmodule

// File: rtl/hs_tracker.sv
module hs_tracker
    import hs_pkg::*;
#(
    parameter int NW = HS_WIRES,
    parameter int SW = STATE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NW-1:0] wires_i,
    input  logic          fault_force_i,
    output logic [SW-1:0] state_o,
    output logic          state_chg_o,
    output logic [SW-1:0] prev_state_o
);
    hs_state_e dec_s;
    hs_state_e sel_s;
    hs_state_e cur_s;
    hs_state_e old_s;

    hs_decode #(.NW(NW)) u_decode (
        .wires   (wires_i),
        .decoded (dec_s)
    );

    hs_override u_override (
        .force_fault (fault_force_i),
        .decoded     (dec_s),
        .chosen      (sel_s)
    );

    hs_state_reg u_reg (
        .clk  (clk),
        .rst  (rst),
        .nxt  (sel_s),
        .cur  (cur_s),
        .prev (old_s),
        .chg  (state_chg_o)
    );

    assign state_o      = SW'(cur_s);
    assign prev_state_o = SW'(old_s);
endmodule

// File: rtl/hs_tracker_chk.sv
module hs_tracker_chk (
    input logic       clk,
    input logic       rst,
    input logic [9:0] wires_i,
    input logic       fault_force_i,
    input logic [3:0] state_o,
    input logic       state_chg_o,
    input logic [3:0] prev_state_o
);
    // R1
    estop_dominates_chk: assert property (@(posedge clk) disable iff (rst)
        (wires_i[9] && !fault_force_i) |=> (state_o == 4'd7));

    // R2
    compt_complete_chk: assert property (@(posedge clk) disable iff (rst)
        (wires_i[5] && !wires_i[9] && !fault_force_i) |=> (state_o == 4'd6));

    // R3
    busy_transfer_chk: assert property (@(posedge clk) disable iff (rst)
        (wires_i[4] && !wires_i[5] && !wires_i[9] && !fault_force_i) |=> (state_o == 4'd5));

    // R7
    strobe_means_change_chk: assert property (@(posedge clk) disable iff (rst)
        state_chg_o |-> (state_o != prev_state_o));

    // R7
    quiet_means_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !state_chg_o |=> (state_chg_o || $stable(state_o)));

    // R8
    prev_tracks_chk: assert property (@(posedge clk) disable iff (rst)
        state_chg_o |=> (state_chg_o ? (prev_state_o == $past(state_o)) : $stable(prev_state_o)));

    // R9
    fault_force_chk: assert property (@(posedge clk) disable iff (rst)
        fault_force_i |=> (state_o == 4'd8));

    // R10
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (state_o == 4'd0 && prev_state_o == 4'd0 && !state_chg_o));
endmodule

bind hs_tracker hs_tracker_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .wires_i       (wires_i),
    .fault_force_i (fault_force_i),
    .state_o       (state_o),
    .state_chg_o   (state_chg_o),
    .prev_state_o  (prev_state_o)
);

// File: tb/tb_hs_tracker.sv
`timescale 1ns/1ps
module tb_hs_tracker;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] wires = '0;
    logic       ff = 1'b0;
    logic [3:0] st;
    logic       chg;
    logic [3:0] pst;

    int compared = 0;
    int mismatched = 0;
    int strobes = 0;
    logic [3:0] exp_st = 4'd0;
    logic [3:0] exp_pst = 4'd0;
    logic       exp_chg = 1'b0;

    always #4 clk = ~clk;

    hs_tracker dut (
        .clk(clk), .rst(rst), .wires_i(wires), .fault_force_i(ff),
        .state_o(st), .state_chg_o(chg), .prev_state_o(pst)
    );

    function automatic logic [3:0] model(input logic [9:0] w, input logic f);
        if (f)                      return 4'd8;
        if (w[9])                   return 4'd7;
        if (w[5])                   return 4'd6;
        if (w[4])                   return 4'd5;
        if (w[6])                   return 4'd3;
        if (w[7])                   return 4'd4;
        if (w[2] && (w[0] || w[1])) return 4'd2;
        if (w[0] || w[1])           return 4'd1;
        return 4'd0;
    endfunction

    function automatic string rule(input logic [9:0] w, input logic f);
        if (f)              return "R9";
        if (w[9])           return "R1";
        if (w[5])           return "R2";
        if (w[4])           return "R3";
        if (w[6] || w[7])   return "R4";
        return "R5";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Apply inputs, wait one edge, then compare everything
    task automatic step(input logic [9:0] w, input logic f, input string tag);
        logic [3:0] nx;
        wires = w;
        ff = f;
        @(posedge clk);
        #2;
        nx = model(w, f);
        exp_chg = (nx != exp_st);
        if (exp_chg) begin
            exp_pst = exp_st;
            exp_st = nx;
        end
        if (chg) strobes++;
        check((tag.len() != 0) ? tag : rule(w, f), st, exp_st);
        check("R7", chg, exp_chg);
        check("R8", pst, exp_pst);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        #2;
        exp_st = 0; exp_pst = 0; exp_chg = 0;
        check("R10", st, 4'd0);
        check("R10", pst, 4'd0);
        check("R10", chg, 1'b0);
        rst = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        mismatched++;
        compared++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [9:0] w;
        logic       f;
        void'($urandom(32'd20240611));
        repeat (2) @(posedge clk);
        #2;
        do_reset();

        // Directed load trace: six transitions, R4 and R3 ordering
        strobes = 0;
        step(10'h001, 0, "R5");                 // carrier present
        step(10'h005, 0, "R5");                 // valid asserted
        step(10'h045, 0, "R4");                 // load ready
        step(10'h055, 0, "R3");                 // transferring
        step(10'h045, 0, "R4");                 // BUSY drops, L_REQ high
        step(10'h025, 0, "R2");                 // complete
        step(10'h025, 0, "R7");                 // same value: no strobe
        check("R7", strobes, 6);

        // Unload path and L_REQ priority
        step(10'h082, 0, "R4");
        check("R4", st, 4'd4);
        step(10'h0C2, 0, "R4");
        check("R4", st, 4'd3);
        // VALID without carrier select is Idle
        step(10'h004, 0, "R5");
        check("R5", st, 4'd0);

        // R6: TR_REQ and READY ignored
        step(10'h001, 0, "R6");
        strobes = 0;
        step(10'h009, 0, "R6");
        step(10'h109, 0, "R6");
        step(10'h101, 0, "R6");
        check("R6", st, 4'd1);
        check("R6", strobes, 0);

        // R1: ES over everything, then release
        step(10'h3FF, 0, "R1");
        step(10'h2F5, 0, "R1");
        step(10'h0F5, 0, "R1");
        check("R1", st, 4'd6);

        // R9: fault over ES, then resume
        step(10'h200, 1, "R9");
        step(10'h200, 0, "R9");
        check("R9", st, 4'd7);

        // Reset from a non-idle state
        step(10'h010, 0, "R3");
        do_reset();

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            w = 10'($urandom);
            if (($urandom % 8) != 0) w[9] = 1'b0;
            if (($urandom % 3) != 0) w[5] = 1'b0;
            if (($urandom % 2) != 0) w[4] = 1'b0;
            f = (($urandom % 16) == 0);
            if (($urandom % 4) == 0) w = wires;  // repeat: strobe check
            step(w, f, "");
            if (($urandom % 500) == 0) do_reset();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule